// File: doc/BRIEF.md
# Flash Status and Configuration Registers

This block keeps the status byte and the configuration register of a synchronous flash memory controller. The internal write state machine reports its busy level and its result events: illegal command, block-erase failure, word-program failure, low regulator voltage and program supply below its low threshold. Failure events are kept in sticky flags. Only the clear-status command resets these flags. The state machine has no way to clear them.

The command path decodes three command bytes. One loads the configuration register from a 32-bit data word. One requests a readback of the configuration register. One clears the sticky status flags. Configuration bit 4 picks how status bits 5 and 4 are read. When it is 0, they show one combined failure flag and one regulator flag. When it is 1, they show a separate erase result and a separate program result. The status byte follows the flags without delay. A configuration readback is given one cycle after its command.

Top module: `flash_stat_cfg`

## Requirements
- R1: Status bit 7 is 1 when `wsm_busy` is 0 (ready) and 0 while `wsm_busy` is 1.
- R2: Status bit 6 always reads 0.
- R3: When configuration bit 4 is 0, status bit 5 is a sticky failure flag. It is set on the edge after `evt_illegal`, `evt_erase_err` or `evt_prog_err` is high, and it stays set until a clear command.
- R4: When configuration bit 4 is 1, status bit 5 is a sticky erase-failure flag set by `evt_erase_err`, and status bit 4 is a sticky program-failure flag set by `evt_prog_err`.
- R5: When configuration bit 4 is 0, status bit 4 is set on the edge after `lrv_in` is high while `wsm_busy` is 1. `lrv_in` has no effect while `wsm_busy` is 0.
- R6: Status bit 3 is set on the edge after `supply_low` is high while `wsm_busy` is 1, and it stays set until a clear command.
- R7: Status bit 2 equals configuration bit 2: 1 means byte-by-byte programming and 0 means full-word programming.
- R8: Status bit 1 equals configuration bit 1, the overlay permission. Status bit 0 is 1 only when configuration bits 1 and 0 are both 1 and `vpp_high` is 1.
- R9: A command byte of 0x96 with `cmd_valid` loads the configuration register from `cmd_data` on that clock edge.
- R10: Only configuration bits 0–7, 24, 25 and 28–31 are writable. Bits 8–23, 26 and 27 are not stored and always read 0.
- R11: A command byte of 0x90 with `addr_lo` = 2'b10 makes `cfg_rd_valid` 1 and puts the configuration on `cfg_rd` in the next cycle. In any other cycle, both outputs are 0.
- R12: A command byte of 0x50 clears every sticky flag (status bits 5, 4 and 3) on that edge. If an event that sets a flag arrives in the same cycle as the clear, that flag ends up set.
- R13: Reset clears the configuration and all flags. While idle after reset, the status byte reads 0x80 and a readback returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte is valid this cycle |
| cmd_byte | input | 8 | Command code |
| cmd_data | input | 32 | Value for a configuration load |
| addr_lo | input | 2 | Low address bits that qualify a readback |
| wsm_busy | input | 1 | State machine is running an erase or program |
| evt_illegal | input | 1 | Illegal command event |
| evt_erase_err | input | 1 | Block-erase failure event |
| evt_prog_err | input | 1 | Word-program failure event |
| lrv_in | input | 1 | Low regulator voltage level |
| supply_low | input | 1 | Program supply is below its low threshold |
| vpp_high | input | 1 | Program supply is at or above its high threshold |
| status | output | 8 | Status byte |
| cfg_rd | output | 32 | Configuration readback value |
| cfg_rd_valid | output | 1 | Readback value is valid |

## Verification
A clear command and a new failure event can arrive in the same clock cycle. Both act on the same sticky flags. The bench provokes this twice. First it issues the clear while an illegal-command event is present and an old supply flag is pending. It expects the old supply flag to drop and the failure flag to be set on the following edge. Second, an assertion checks that a clear arriving together with an erase failure always leaves status bit 5 set in either interpretation mode.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
  localparam int CMD_W   = 8;
  localparam int CFG_W   = 32;
  localparam int STAT_W  = 8;
  localparam int ADDR_W  = 2;
  localparam logic [CMD_W-1:0]  OP_LOAD  = 8'h96;
  localparam logic [CMD_W-1:0]  OP_READ  = 8'h90;
  localparam logic [CMD_W-1:0]  OP_CLEAR = 8'h50;
  localparam logic [ADDR_W-1:0] RD_ADDR  = 2'b10;
  localparam logic [CFG_W-1:0]  CFG_WMASK = 32'hF300_00FF;
  localparam int MODE_BIT   = 4;
  localparam int BYTEPG_BIT = 2;
  localparam int OVL_PERM   = 1;
  localparam int OVL_REQ    = 0;
  // sticky flag slots
  localparam int FL_FAIL  = 0;
  localparam int FL_LRV   = 1;
  localparam int FL_SUPP  = 2;
  localparam int FL_ERASE = 3;
  localparam int FL_PROG  = 4;
  localparam int NFLAG    = 5;
endpackage

// File: rtl/fsc_rst_sync.sv
module fsc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb sr_d = {sr_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign rst_q = sr_q[STAGES-1];
endmodule

// File: rtl/fsc_sticky_bank.sv
module fsc_sticky_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;
  logic [N-1:0] flag_d;

  for (genvar i = 0; i < N; i++) begin : g_flag
    // a set in the clearing cycle wins
    always_comb flag_d[i] = set_i[i] | (flag_q[i] & ~clr_i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_d[i];
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/fsc_cfg_reg.sv
module fsc_cfg_reg #(
  parameter int              W     = 32,
  parameter logic [W-1:0]    WMASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] din_i,
  input  logic         rd_req_i,
  output logic [W-1:0] cfg_o,
  output logic [W-1:0] rd_data_o,
  output logic         rd_valid_o
);
  logic [W-1:0] cfg_q, cfg_d;
  logic [W-1:0] rd_q, rd_d;
  logic         rv_q, rv_d;

  always_comb begin
    cfg_d = cfg_q;
    if (load_i) cfg_d = din_i & WMASK;
    rv_d = rd_req_i;
    rd_d = rd_req_i ? cfg_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      rd_q  <= '0;
      rv_q  <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      rd_q  <= rd_d;
      rv_q  <= rv_d;
    end
  end

  assign cfg_o      = cfg_q;
  assign rd_data_o  = rd_q;
  assign rd_valid_o = rv_q;
endmodule

// File: rtl/fsc_status_map.sv
module fsc_status_map
  import flash_stat_pkg::*;
(
  input  logic [NFLAG-1:0] flag_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             busy_i,
  input  logic             vpp_high_i,
  output logic [STAT_W-1:0] status_o
);
  logic split_mode;

  always_comb begin
    split_mode  = cfg_i[MODE_BIT];
    status_o    = '0;
    status_o[7] = ~busy_i;
    status_o[6] = 1'b0;
    status_o[5] = split_mode ? flag_i[FL_ERASE] : flag_i[FL_FAIL];
    status_o[4] = split_mode ? flag_i[FL_PROG]  : flag_i[FL_LRV];
    status_o[3] = flag_i[FL_SUPP];
    status_o[2] = cfg_i[BYTEPG_BIT];
    status_o[1] = cfg_i[OVL_PERM];
    status_o[0] = cfg_i[OVL_PERM] & cfg_i[OVL_REQ] & vpp_high_i;
  end
endmodule

// File: rtl/flash_stat_cfg.sv
module flash_stat_cfg
  import flash_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_byte,
  input  logic [CFG_W-1:0]  cmd_data,
  input  logic [ADDR_W-1:0] addr_lo,
  input  logic              wsm_busy,
  input  logic              evt_illegal,
  input  logic              evt_erase_err,
  input  logic              evt_prog_err,
  input  logic              lrv_in,
  input  logic              supply_low,
  input  logic              vpp_high,
  output logic [STAT_W-1:0] status,
  output logic [CFG_W-1:0]  cfg_rd,
  output logic              cfg_rd_valid
);
  logic             rst_q;
  logic             do_load, do_read, do_clear;
  logic [NFLAG-1:0] flag_set, flags;
  logic [CFG_W-1:0] cfg;

  fsc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q(rst_q)
  );

  always_comb begin
    do_load  = cmd_valid && (cmd_byte == OP_LOAD);
    do_read  = cmd_valid && (cmd_byte == OP_READ) && (addr_lo == RD_ADDR);
    do_clear = cmd_valid && (cmd_byte == OP_CLEAR);
    flag_set           = '0;
    flag_set[FL_FAIL]  = evt_illegal | evt_erase_err | evt_prog_err;
    flag_set[FL_LRV]   = lrv_in & wsm_busy;
    flag_set[FL_SUPP]  = supply_low & wsm_busy;
    flag_set[FL_ERASE] = evt_erase_err;
    flag_set[FL_PROG]  = evt_prog_err;
  end

  fsc_sticky_bank #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_q), .set_i(flag_set), .clr_i(do_clear), .flag_o(flags)
  );

  fsc_cfg_reg #(.W(CFG_W), .WMASK(CFG_WMASK)) u_cfg (
    .clk(clk), .rst_n(rst_q), .load_i(do_load), .din_i(cmd_data),
    .rd_req_i(do_read), .cfg_o(cfg), .rd_data_o(cfg_rd), .rd_valid_o(cfg_rd_valid)
  );

  fsc_status_map u_map (
    .flag_i(flags), .cfg_i(cfg), .busy_i(wsm_busy), .vpp_high_i(vpp_high),
    .status_o(status)
  );
endmodule

// File: rtl/flash_stat_cfg_chk.sv
module flash_stat_cfg_chk
  import flash_stat_pkg::*;
(
  input logic              clk,
  input logic              rst_q,
  input logic              cmd_valid,
  input logic [CMD_W-1:0]  cmd_byte,
  input logic [ADDR_W-1:0] addr_lo,
  input logic              wsm_busy,
  input logic              evt_illegal,
  input logic              evt_erase_err,
  input logic              evt_prog_err,
  input logic              lrv_in,
  input logic              supply_low,
  input logic [STAT_W-1:0] status,
  input logic [CFG_W-1:0]  cfg_rd,
  input logic              cfg_rd_valid
);
  logic clr_c, load_c, read_c, quiet_c;
  assign clr_c   = cmd_valid && cmd_byte == OP_CLEAR;
  assign load_c  = cmd_valid && cmd_byte == OP_LOAD;
  assign read_c  = cmd_valid && cmd_byte == OP_READ && addr_lo == RD_ADDR;
  assign quiet_c = !evt_illegal && !evt_erase_err && !evt_prog_err
                   && !lrv_in && !supply_low;

  a_r1_ready: assert property (@(posedge clk) disable iff (!rst_q)
    status[7] != wsm_busy);
  a_r2_bit6_zero: assert property (@(posedge clk) disable iff (!rst_q)
    status[6] == 1'b0);
  a_r3_bit5_sticky: assert property (@(posedge clk) disable iff (!rst_q)
    (status[5] && !clr_c && !load_c) |=> status[5]);
  a_r6_supply_sets: assert property (@(posedge clk) disable iff (!rst_q)
    (wsm_busy && supply_low) |=> status[3]);
  a_r10_unwritable_zero: assert property (@(posedge clk) disable iff (!rst_q)
    cfg_rd_valid |-> ((cfg_rd & ~CFG_WMASK) == '0));
  a_r11_read_valid: assert property (@(posedge clk) disable iff (!rst_q)
    read_c |=> cfg_rd_valid);
  a_r11_no_read: assert property (@(posedge clk) disable iff (!rst_q)
    !read_c |=> (!cfg_rd_valid && cfg_rd == '0));
  a_r12_clear: assert property (@(posedge clk) disable iff (!rst_q)
    (clr_c && quiet_c) |=> (status[5:3] == 3'b000));
  a_r12_event_wins: assert property (@(posedge clk) disable iff (!rst_q)
    (clr_c && evt_erase_err) |=> status[5]);
endmodule

bind flash_stat_cfg flash_stat_cfg_chk u_chk (
  .clk(clk), .rst_q(rst_q), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
  .addr_lo(addr_lo), .wsm_busy(wsm_busy), .evt_illegal(evt_illegal),
  .evt_erase_err(evt_erase_err), .evt_prog_err(evt_prog_err), .lrv_in(lrv_in),
  .supply_low(supply_low), .status(status), .cfg_rd(cfg_rd),
  .cfg_rd_valid(cfg_rd_valid)
);

// File: tb/flash_stat_cfg_test.sv
`timescale 1ns/1ps
module flash_stat_cfg_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [7:0]  cmd_byte;
  logic [31:0] cmd_data;
  logic [1:0]  addr_lo;
  logic        wsm_busy, evt_illegal, evt_erase_err, evt_prog_err;
  logic        lrv_in, supply_low, vpp_high;
  logic [7:0]  status;
  logic [31:0] cfg_rd;
  logic        cfg_rd_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flash_stat_cfg uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .cmd_data(cmd_data), .addr_lo(addr_lo), .wsm_busy(wsm_busy),
    .evt_illegal(evt_illegal), .evt_erase_err(evt_erase_err),
    .evt_prog_err(evt_prog_err), .lrv_in(lrv_in), .supply_low(supply_low),
    .vpp_high(vpp_high), .status(status), .cfg_rd(cfg_rd),
    .cfg_rd_valid(cfg_rd_valid)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        cv;
    logic [7:0]  cmd;
    logic [31:0] dat;
    logic [1:0]  adr;
    logic        busy, ill, eer, per, lrv, vlo, vhi;
    logic [7:0]  est;
    logic        erv;
    logic [31:0] erd;
  } vec_t;

  localparam int NV = 22;
  // fields: req, cv, cmd, data, addr, busy, ill, eer, per, lrv, vlo, vhi, status, rv, rd
  localparam vec_t VECS [NV] = '{
    '{4'd13,1'b0,8'h00,32'h0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h80,1'b0,32'h0}, // R13 idle
    '{4'd1, 1'b0,8'h00,32'h0,2'b00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,32'h0}, // R1 busy
    '{4'd3, 1'b0,8'h00,32'h0,2'b00,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h20,1'b0,32'h0}, // R3 illegal
    '{4'd3, 1'b0,8'h00,32'h0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'hA0,1'b0,32'h0}, // R3 holds
    '{4'd12,1'b1,8'h50,32'h0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h80,1'b0,32'h0}, // R12 clear
    '{4'd5, 1'b0,8'h00,32'h0,2'b00,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h10,1'b0,32'h0}, // R5 lrv busy
    '{4'd12,1'b1,8'h50,32'h0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h80,1'b0,32'h0}, // R12 clear
    '{4'd5, 1'b0,8'h00,32'h0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h80,1'b0,32'h0}, // R5 lrv idle
    '{4'd6, 1'b0,8'h00,32'h0,2'b00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,8'h08,1'b0,32'h0}, // R6 supply
    '{4'd12,1'b1,8'h50,32'h0,2'b00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'hA0,1'b0,32'h0}, // R12 event wins
    '{4'd12,1'b1,8'h50,32'h0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h80,1'b0,32'h0}, // R12 clear
    '{4'd9, 1'b1,8'h96,32'hFFFF_FFFF,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h86,1'b0,32'h0}, // R9 R7 load
    '{4'd10,1'b1,8'h90,32'h0,2'b10,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'h87,1'b1,32'hF300_00FF}, // R10 R8
    '{4'd11,1'b1,8'h90,32'h0,2'b11,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h86,1'b0,32'h0}, // R11 bad addr
    '{4'd4, 1'b0,8'h00,32'h0,2'b00,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h26,1'b0,32'h0}, // R4 erase
    '{4'd4, 1'b0,8'h00,32'h0,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'hB6,1'b0,32'h0}, // R4 program
    '{4'd3, 1'b1,8'h96,32'h0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'hA0,1'b0,32'h0}, // R3 mode 0
    '{4'd8, 1'b1,8'h96,32'h35,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'hB4,1'b0,32'h0}, // R8 no perm
    '{4'd9, 1'b1,8'h90,32'h0,2'b10,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'hB4,1'b1,32'h35}, // R9 readback
    '{4'd12,1'b1,8'h50,32'h0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h84,1'b0,32'h0}, // R12 mode 1
    '{4'd10,1'b1,8'h96,32'h0C00_FF00,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h80,1'b0,32'h0}, // R10
    '{4'd10,1'b1,8'h90,32'h0,2'b10,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h80,1'b1,32'h0}  // R10 read
  };

  task automatic idle_inputs();
    cmd_valid = 1'b0; cmd_byte = '0; cmd_data = '0; addr_lo = '0;
    wsm_busy = 1'b0; evt_illegal = 1'b0; evt_erase_err = 1'b0;
    evt_prog_err = 1'b0; lrv_in = 1'b0; supply_low = 1'b0; vpp_high = 1'b0;
  endtask

  task automatic check(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) tick();

    for (int i = 0; i < NV; i++) begin
      cmd_valid = VECS[i].cv;   cmd_byte = VECS[i].cmd;
      cmd_data  = VECS[i].dat;  addr_lo  = VECS[i].adr;
      wsm_busy  = VECS[i].busy; evt_illegal = VECS[i].ill;
      evt_erase_err = VECS[i].eer; evt_prog_err = VECS[i].per;
      lrv_in = VECS[i].lrv; supply_low = VECS[i].vlo; vpp_high = VECS[i].vhi;
      tick();
      check(VECS[i].req, $sformatf("vec %0d status", i), {24'h0, status}, {24'h0, VECS[i].est});
      check(VECS[i].req, $sformatf("vec %0d rd_valid", i), {31'h0, cfg_rd_valid}, {31'h0, VECS[i].erv});
      check(VECS[i].req, $sformatf("vec %0d rd_data", i), cfg_rd, VECS[i].erd);
    end

    // R13: reset in the middle of activity
    idle_inputs();
    cmd_valid = 1'b1; cmd_byte = 8'h96; cmd_data = 32'h0000_0017;
    tick();
    idle_inputs();
    wsm_busy = 1'b1; evt_illegal = 1'b1; supply_low = 1'b1;
    tick();
    idle_inputs();
    #1 rst_n = 1'b0;
    #1 check(13, "status in reset", {24'h0, status}, 32'h80);
    tick();
    #1 rst_n = 1'b1;
    repeat (3) tick();
    check(13, "status after reset", {24'h0, status}, 32'h80);
    cmd_valid = 1'b1; cmd_byte = 8'h90; addr_lo = 2'b10;
    tick();
    idle_inputs();
    check(13, "cfg after reset valid", {31'h0, cfg_rd_valid}, 32'h1);
    check(13, "cfg after reset data", cfg_rd, 32'h0);
    tick();
    check(11, "valid drops", {31'h0, cfg_rd_valid}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R13 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule